// File: doc/BRIEF.md
# Fragment-to-Frame Reassembler

This block rebuilds complete link-layer frames from a byte stream of short fragments. Every fragment opens with a two-byte header, most significant byte first, followed by the payload bytes that the header's length field announces. Two header flags say whether the fragment continues a frame that is already open and whether more fragments of that frame follow. A three-state tracker checks these flags against the frame in progress.

Payload bytes pass straight from the input stream to the output stream. The output stream applies backpressure through a ready signal, and it marks the first byte of each frame and the final byte of the frame's closing fragment. A fragment with a bad length, a continuation that belongs to no open frame, a new frame that cuts into an open one, and a frame that grows past the size limit each raise a one-cycle error pulse. Downstream logic treats that pulse as the end of any partial frame it holds.

Top module: `frag_reassembler`

## Requirements
- R1: A header is two bytes, bits 15:8 first and bits 7:0 second. Bit 15 set means "not the first fragment of a frame". Bit 14 set means "not the last fragment". Bits 8:0 give the payload length in bytes. Bits 13:9 have no effect on behaviour, and payload bytes reach out_data unchanged.
- R2: frame_state reads 0 while no frame is open, 1 while a frame waits for further fragments, and 2 while the payload of a frame's closing fragment is in flight. It returns to 0 after the byte marked last has been taken.
- R3: During payload, out_valid follows in_valid and in_ready follows out_ready. During header bytes and discarded bytes, in_ready is 1 and out_valid is 0.
- R4: out_first is 1 on the first payload byte of each frame and 0 on all other bytes.
- R5: out_last is 1 on the final payload byte of a fragment whose bit 14 is clear, and 0 on all other bytes.
- R6: A fragment with length 0 or above MAX_FRAG (default 280) has its payload discarded whole. It raises the error pulse and leaves frame_state at 0.
- R7: A fragment with bit 15 set that arrives while frame_state is 0 is discarded and raises the error pulse. frame_state stays 0.
- R8: A fragment with bit 15 clear that arrives while frame_state is 1 raises the error pulse and opens a new frame. Its first byte carries out_first.
- R9: A fragment that would take the frame's total length past MAX_FRAME (default 1500) is discarded, raises the error pulse, and returns frame_state to 0. A total exactly equal to MAX_FRAME is accepted.
- R10: frame_err is high only in the single cycle after the second header byte of a rejected or frame-cutting fragment is accepted.
- R11: After reset, frame_state is 0, frame_err is 0, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Input byte (header or payload) |
| out_valid | output | 1 | Output payload byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output payload byte |
| out_first | output | 1 | First byte of a frame |
| out_last | output | 1 | Last byte of a frame |
| frame_err | output | 1 | One-cycle framing error pulse |
| frame_state | output | 2 | Frame tracker state (0 idle, 1 open, 2 closing) |

## Verification
The error pulse and the first byte of a new frame can fall in the same cycle. A fragment that starts a new frame while another is open flags the error and forwards its first byte, with the start marker, in the cycle right after its header. The bench feeds that payload byte back to back with the header. In that one cycle it checks that frame_err, out_valid and out_first are all high. A second coincidence is checked on the same cycles: the last byte of an accepted frame and the header of the next fragment, with the state expected to be back at 0 when the next header completes. Sweeps over every flag pair and every length from 0 past the fragment limit, in a small configuration, run both collisions from every reachable state.

// File: rtl/reasm_pkg.sv
package reasm_pkg;
  localparam int HDR_W     = 16;
  localparam int LEN_W     = 9;
  localparam int NB_BIT    = 15;  // continuation flag position
  localparam int NE_BIT    = 14;  // more-follows flag position

  // Frame tracker encoding is visible at the port, so keep the values fixed.
  typedef enum logic [1:0] {
    FS_BEGIN  = 2'd0,
    FS_MIDDLE = 2'd1,
    FS_END    = 2'd2
  } frame_st_e;

  typedef enum logic [1:0] {
    PH_HDR_HI,
    PH_HDR_LO,
    PH_DATA,
    PH_SKIP
  } phase_e;

  typedef enum logic [2:0] {
    ACT_PASS,
    ACT_RESTART,
    ACT_BAD_LEN,
    ACT_ORPHAN,
    ACT_OVERSIZE
  } act_e;

  typedef struct packed {
    logic             not_begin;
    logic             not_end;
    logic [LEN_W-1:0] len;
  } hdr_t;
endpackage

// File: rtl/reasm_rst_sync.sv
module reasm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/reasm_classify.sv
module reasm_classify
  import reasm_pkg::*;
#(
  parameter int MAX_FRAG  = 280,
  parameter int MAX_FRAME = 1500,
  localparam int ACC_W    = $clog2(MAX_FRAME + 1),
  localparam int TOT_W    = $clog2(MAX_FRAME + (1 << LEN_W) + 1)
) (
  input  logic [HDR_W-1:0] hdr_word,
  input  frame_st_e        fstate,
  input  logic [ACC_W-1:0] acc,
  output hdr_t             hdr,
  output act_e             act,
  output logic [TOT_W-1:0] new_total
);
  localparam logic [LEN_W-1:0] FRAG_LIM  = LEN_W'(MAX_FRAG);
  localparam logic [TOT_W-1:0] FRAME_LIM = TOT_W'(MAX_FRAME);

  logic             bad_len;
  logic [TOT_W-1:0] base;

  always_comb begin
    hdr.not_begin = hdr_word[NB_BIT];
    hdr.not_end   = hdr_word[NE_BIT];
    hdr.len       = hdr_word[LEN_W-1:0];
  end

  always_comb begin
    bad_len   = (hdr.len == '0) || (hdr.len > FRAG_LIM);
    base      = hdr.not_begin ? TOT_W'(acc) : '0;
    new_total = base + TOT_W'(hdr.len);
    if (bad_len)                                act = ACT_BAD_LEN;
    else if (fstate == FS_BEGIN && hdr.not_begin) act = ACT_ORPHAN;
    else if (new_total > FRAME_LIM)             act = ACT_OVERSIZE;
    else if (fstate == FS_MIDDLE && !hdr.not_begin) act = ACT_RESTART;
    else                                        act = ACT_PASS;
  end
endmodule

// File: rtl/reasm_track.sv
module reasm_track
  import reasm_pkg::*;
#(
  parameter int MAX_FRAG  = 280,
  parameter int MAX_FRAME = 1500,
  localparam int ACC_W    = $clog2(MAX_FRAME + 1),
  localparam int TOT_W    = $clog2(MAX_FRAME + (1 << LEN_W) + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_first,
  output logic             out_last,
  output logic             err,
  output frame_st_e        fstate,
  output logic [ACC_W-1:0] acc,
  output logic [7:0]       hdr_hi,
  input  hdr_t             hdr,
  input  act_e             act,
  input  logic [TOT_W-1:0] new_total
);
  localparam logic [LEN_W-1:0] CNT_ONE = LEN_W'(1);

  phase_e           phase_q, phase_d;
  frame_st_e        fstate_q, fstate_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [ACC_W-1:0] acc_q, acc_d;
  logic             first_q, first_d;
  logic             err_q, err_d;
  logic [7:0]       hi_q, hi_d;
  logic             acc_hs;

  assign in_ready  = (phase_q == PH_DATA) ? out_ready : 1'b1;
  assign out_valid = (phase_q == PH_DATA) && in_valid;
  assign out_first = out_valid && first_q;
  assign out_last  = out_valid && (fstate_q == FS_END) && (cnt_q == CNT_ONE);
  assign acc_hs    = in_valid && in_ready;
  assign err       = err_q;
  assign fstate    = fstate_q;
  assign acc       = acc_q;
  assign hdr_hi    = hi_q;

  always_comb begin
    phase_d  = phase_q;
    fstate_d = fstate_q;
    cnt_d    = cnt_q;
    acc_d    = acc_q;
    first_d  = first_q;
    hi_d     = hi_q;
    err_d    = 1'b0;
    if (acc_hs) begin
      unique case (phase_q)
        PH_HDR_HI: begin
          hi_d    = in_data;
          phase_d = PH_HDR_LO;
        end
        PH_HDR_LO: begin
          cnt_d = hdr.len;
          if (act == ACT_PASS || act == ACT_RESTART) begin
            err_d    = (act == ACT_RESTART);
            phase_d  = PH_DATA;
            acc_d    = new_total[ACC_W-1:0];
            fstate_d = hdr.not_end ? FS_MIDDLE : FS_END;
            if (!hdr.not_begin) first_d = 1'b1;
          end else begin
            err_d    = 1'b1;
            fstate_d = FS_BEGIN;
            acc_d    = '0;
            first_d  = 1'b0;
            phase_d  = (hdr.len == '0) ? PH_HDR_HI : PH_SKIP;
          end
        end
        PH_DATA: begin
          cnt_d   = cnt_q - 1'b1;
          first_d = 1'b0;
          if (cnt_q == CNT_ONE) begin
            phase_d = PH_HDR_HI;
            if (fstate_q == FS_END) begin
              fstate_d = FS_BEGIN;
              acc_d    = '0;
            end
          end
        end
        PH_SKIP: begin
          cnt_d = cnt_q - 1'b1;
          if (cnt_q == CNT_ONE) phase_d = PH_HDR_HI;
        end
        default: phase_d = PH_HDR_HI;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_HDR_HI;
      fstate_q <= FS_BEGIN;
      cnt_q    <= '0;
      acc_q    <= '0;
      first_q  <= 1'b0;
      err_q    <= 1'b0;
      hi_q     <= '0;
    end else begin
      phase_q  <= phase_d;
      fstate_q <= fstate_d;
      cnt_q    <= cnt_d;
      acc_q    <= acc_d;
      first_q  <= first_d;
      err_q    <= err_d;
      hi_q     <= hi_d;
    end
  end

  // R2: tracker never reaches the unused code
  assert_state_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fstate_q != 2'd3);

  // R2: a taken closing byte leaves the tracker idle
  assert_close_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_last && out_ready) |=> (fstate_q == FS_BEGIN));

  // R10: the error flag never stretches over two cycles
  assert_err_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> !err_q);

  // R10: the error flag only follows a completed header
  assert_err_origin_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past(phase_q == PH_HDR_LO && acc_hs));

  // R8: an error while payload flows can only be a frame cut-in, so a start is pending
  assert_restart_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && phase_q == PH_DATA) |-> first_q);

  // R6: a malformed length is flagged and closes the frame
  assert_bad_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HDR_LO && acc_hs && act == ACT_BAD_LEN) |=> (err_q && fstate_q == FS_BEGIN));

  // R9: accumulated length stays within the frame limit
  assert_acc_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q <= ACC_W'(MAX_FRAME));
endmodule

// File: rtl/frag_reassembler.sv
module frag_reassembler
  import reasm_pkg::*;
#(
  parameter int MAX_FRAG   = 280,
  parameter int MAX_FRAME  = 1500,
  parameter int RST_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_first,
  output logic       out_last,
  output logic       frame_err,
  output logic [1:0] frame_state
);
  localparam int ACC_W = $clog2(MAX_FRAME + 1);
  localparam int TOT_W = $clog2(MAX_FRAME + (1 << LEN_W) + 1);

  logic             rst_n_sync;
  frame_st_e        fstate;
  logic [ACC_W-1:0] acc;
  logic [7:0]       hdr_hi;
  hdr_t             hdr;
  act_e             act;
  logic [TOT_W-1:0] new_total;

  reasm_rst_sync #(.STAGES(RST_STAGES)) i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  reasm_classify #(.MAX_FRAG(MAX_FRAG), .MAX_FRAME(MAX_FRAME)) i_cls (
    .hdr_word  ({hdr_hi, in_data}),
    .fstate    (fstate),
    .acc       (acc),
    .hdr       (hdr),
    .act       (act),
    .new_total (new_total)
  );

  reasm_track #(.MAX_FRAG(MAX_FRAG), .MAX_FRAME(MAX_FRAME)) i_trk (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_first (out_first),
    .out_last  (out_last),
    .err       (frame_err),
    .fstate    (fstate),
    .acc       (acc),
    .hdr_hi    (hdr_hi),
    .hdr       (hdr),
    .act       (act),
    .new_total (new_total)
  );

  assign out_data    = in_data;
  assign frame_state = fstate;
endmodule

// File: tb/test_frag_reassembler.sv
module test_frag_reassembler;
  localparam int MAXF = 6;
  localparam int MAXT = 14;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       out_ready = 1'b1;
  logic       in_ready, out_valid, out_first, out_last, frame_err;
  logic [7:0] out_data;
  logic [1:0] frame_state;

  int total = 0;
  int bad = 0;
  int mstate = 0;
  int macc = 0;
  bit mfirst = 0;
  bit exp_err = 0;
  string err_tag = "R10";
  int stall_ctr = 0;
  int seq = 0;

  always #4 clk = ~clk;  // 125 MHz

  frag_reassembler #(.MAX_FRAG(MAXF), .MAX_FRAME(MAXT)) i_frag_reassembler (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_first(out_first), .out_last(out_last),
    .frame_err(frame_err), .frame_state(frame_state)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s seq=%0d actual=%0d expected=%0d", tag, seq, act, exp);
    end
  endtask

  // Drive one byte, wait for its handshake, check outputs away from the edge.
  task automatic put_byte(input logic [7:0] d, input bit pay, input bit efirst, input bit elast);
    bit done = 0;
    bit first_look = 1;
    in_valid = 1'b1;
    in_data  = d;
    while (!done) begin
      out_ready = (stall_ctr % 4) != 3;
      stall_ctr++;
      @(negedge clk);
      if (first_look) begin
        chk(frame_err == exp_err, err_tag, int'(frame_err), int'(exp_err));
        chk(int'(frame_state) == mstate, "R2", int'(frame_state), mstate);
        exp_err = 0;
        err_tag = "R10";
        first_look = 0;
      end
      if (pay) begin
        chk(out_valid == 1'b1, "R3", int'(out_valid), 1);
        chk(in_ready == out_ready, "R3", int'(in_ready), int'(out_ready));
        chk(out_data == d, "R1", int'(out_data), int'(d));
        chk(out_first == efirst, "R4", int'(out_first), int'(efirst));
        chk(out_last == elast, "R5", int'(out_last), int'(elast));
      end else begin
        chk(out_valid == 1'b0, "R3", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R3", int'(in_ready), 1);
      end
      done = in_ready;
      @(posedge clk);
      #1;
    end
  endtask

  task automatic send_frag(input bit nb, input bit ne, input int len, input logic [4:0] junk);
    logic [15:0] hw;
    bit pass;
    int tot;
    seq++;
    hw = {nb, ne, junk, 9'(len)};  // R1: bits 13:9 carry junk
    put_byte(hw[15:8], 0, 0, 0);
    put_byte(hw[7:0], 0, 0, 0);
    pass = 0;
    tot = nb ? macc + len : len;
    if (len == 0 || len > MAXF) begin
      exp_err = 1; err_tag = "R6";
    end else if (mstate == 0 && nb) begin
      exp_err = 1; err_tag = "R7";
    end else if (tot > MAXT) begin
      exp_err = 1; err_tag = "R9";
    end else begin
      pass = 1;
      if (mstate == 1 && !nb) begin exp_err = 1; err_tag = "R8"; end
    end
    if (pass) begin
      macc = tot;
      if (!nb) mfirst = 1;
      mstate = ne ? 1 : 2;
      for (int i = 0; i < len; i++) begin
        bit ef, el;
        ef = mfirst;
        el = (i == len - 1) && (mstate == 2);
        mfirst = 0;
        put_byte(8'((seq * 7 + i * 13) & 255), 1, ef, el);
      end
      if (mstate == 2) begin mstate = 0; macc = 0; end
    end else begin
      mstate = 0; macc = 0; mfirst = 0;
      for (int i = 0; i < len; i++) put_byte(8'(i + 8'hA0), 0, 0, 0);
    end
  endtask

  task automatic idle_check();
    in_valid = 1'b0;
    @(negedge clk);
    chk(frame_err == exp_err, err_tag, int'(frame_err), int'(exp_err));
    chk(int'(frame_state) == mstate, "R2", int'(frame_state), mstate);
    exp_err = 0; err_tag = "R10";
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    @(negedge clk);
    // R11: state right after reset
    chk(int'(frame_state) == 0, "R11", int'(frame_state), 0);
    chk(frame_err == 1'b0, "R11", int'(frame_err), 0);
    chk(out_valid == 1'b0, "R11", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R11", int'(in_ready), 1);
    @(posedge clk);
    #1;

    // Sweep lengths across the fragment limit with every flag pair, two junk patterns (R1).
    for (int j = 0; j < 2; j++)
      for (int l = 0; l <= MAXF + 2; l++)
        for (int f = 0; f < 4; f++)
          send_frag(f[1], f[0], l, j == 0 ? 5'h00 : 5'h1F);
    idle_check();

    // R9: exact limit accepted
    send_frag(0, 1, 6, 5'h0A);
    send_frag(1, 1, 6, 5'h0A);
    send_frag(1, 0, 2, 5'h0A);
    // R9: one past the limit
    send_frag(0, 1, 6, 5'h05);
    send_frag(1, 1, 6, 5'h05);
    send_frag(1, 0, 3, 5'h05);
    // R7: continuation after abort
    send_frag(1, 0, 2, 5'h00);
    // R8: cut-in restart with payload right behind the header
    send_frag(0, 1, 3, 5'h00);
    send_frag(0, 0, 4, 5'h00);
    // R6: oversize while a frame is open
    send_frag(0, 1, 2, 5'h00);
    send_frag(1, 0, MAXF + 1, 5'h00);
    send_frag(0, 0, 1, 5'h00);
    idle_check();
    finish_run();
  end
endmodule